// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM with Separate Read and Write Ports

This block is an on-chip memory with one read port and one write port. The two ports share a single address bus, which is time-multiplexed across the two halves of each input clock cycle. Every access moves two words: a write takes one word on each half of the input cycle, and a read returns one word on each half of a later cycle. Reads and writes may be issued in the same input cycle.

The input clock pair is replaced by one fast clock running at twice the input rate and a phase bit, `kHigh`. When `kHigh` is 1 the edge is the positive-phase edge, and when it is 0 the edge is the negative-phase edge. The phase bit must alternate on every fast edge. The storage is split into two banks, each half the total depth. The address picks a word pair, and the position of a word within the burst picks the bank.

Read data comes with a valid flag that stands in for an output driver that is switched off. While the flag is low, the data output is zero.

Top module: `burst2_sram`

## Requirements
- R1: While `rstN` is low, `rdValid` is 0 and `rdData` is 0.
- R2: When `wrSelN` is 0 at a positive-phase edge, that cycle performs a write. The word on `wrData` at the positive-phase edge goes to burst position 0 and the word at the following negative-phase edge goes to position 1, both at the address sampled on that negative-phase edge. A read issued in a later input cycle sees the new data.
- R3: When `wrSelN` is 1 at a positive-phase edge, the data, lane selects and address of that cycle leave the memory unchanged.
- R4: `byteSelN` has DATA_W/9 active-low bits. Bit L set to 0 writes bits 9L+8..9L of the word, and bit L set to 1 keeps the stored lane.
- R5: The lane selects are sampled on the same edge as the word they qualify, so the two words of one burst may carry different masks.
- R6: When `rdSelN` is 0 at a positive-phase edge, a read of the address on that edge begins. Position 0 is output on the positive-phase edge of the next input cycle, and position 1 on the negative-phase edge that follows.
- R7: A single read holds `rdValid` high for exactly those two phases. Reads in consecutive input cycles give an unbroken valid window carrying the four words in order.
- R8: Once the read port is deselected, the burst in flight still completes. `rdValid` then falls, and `rdData` returns to 0, at the next positive-phase edge.
- R9: A read and a write to the same word pair in the same input cycle return the pair as it was before the write. A read in the next input cycle returns the new pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the input rate |
| rstN | input | 1 | Asynchronous active-low reset |
| kHigh | input | 1 | Phase bit: 1 = positive-phase edge, 0 = negative-phase edge |
| rdSelN | input | 1 | Active-low read select, sampled on positive-phase edges |
| wrSelN | input | 1 | Active-low write select, sampled on positive-phase edges |
| addr | input | ADDR_W | Shared address: read address on the positive phase, write address on the negative phase |
| wrData | input | DATA_W | Write word, sampled on both phases |
| byteSelN | input | DATA_W/9 | Active-low 9-bit lane write selects, sampled with each word |
| rdData | output | DATA_W | Read word, 0 while not valid |
| rdValid | output | 1 | High while a read word is driven |

## Verification
A read command sampled at a positive-phase edge has its first word registered two fast-clock edges later and its second word one edge after that. At the moment the driver issues each command, it computes both due edge indices and queues them, together with the expected pair taken from a reference array. The monitor samples on every falling edge of the fast clock. When the head of the queue is due, it compares the word. Otherwise it requires the valid flag low and the data zero, which pins down the deselect timing.

A write updates the reference array at the end of its input cycle. A same-cycle read therefore expects the old pair, and a read in the next cycle expects the new one.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
  // Strobes from control to datapath, valid for the current fast-clock edge
  typedef struct packed {
    logic capWord0;    // positive phase: hold first write word and its mask
    logic capRead;     // positive phase with read select: latch both banks
    logic commitWrite; // negative phase of a selected write cycle
    logic drvFirst;    // positive phase: drive burst position 0
    logic drvSecond;   // negative phase: drive burst position 1
    logic drvIdle;     // positive phase with nothing to drive
  } strobe_t;
endpackage

// File: rtl/burst2_bank.sv
module burst2_bank #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          wAddr,
  input  logic [DATA_W-1:0]          wData,
  input  logic [DATA_W/LANE_W-1:0]   wMaskN,
  input  logic [ADDR_W-1:0]          rAddr,
  output logic [DATA_W-1:0]          rData
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wMaskN[l]) mem[wAddr][l*LANE_W +: LANE_W] <= wData[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rData = mem[rAddr];
endmodule

// File: rtl/burst2_ctrl.sv
module burst2_ctrl
  import burst2_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    kHigh,
  input  logic    rdSelN,
  input  logic    wrSelN,
  output strobe_t strb
);
  logic rdIssued;   // read command taken in the current input cycle
  logic outOn;      // a burst is being driven in the current input cycle
  logic wrPending;  // write command taken at the last positive phase

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIssued  <= 1'b0;
      outOn     <= 1'b0;
      wrPending <= 1'b0;
    end else if (kHigh) begin
      rdIssued  <= ~rdSelN;
      outOn     <= rdIssued;
      wrPending <= ~wrSelN;
    end
  end

  always_comb begin
    strb.capWord0    = kHigh;
    strb.capRead     = kHigh & ~rdSelN;
    strb.commitWrite = ~kHigh & wrPending;
    strb.drvFirst    = kHigh & rdIssued;
    strb.drvIdle     = kHigh & ~rdIssued;
    strb.drvSecond   = ~kHigh & outOn;
  end

  // Phase bit must alternate (R2, R6 depend on it)
  assert_phase_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    kHigh |=> !kHigh);

  // Write commit only follows a selected positive phase (R2, R3)
  assert_write_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |-> ($past(kHigh) && !$past(wrSelN)));

  // Output start is three fast edges after the read command (R6)
  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outOn) |-> ($past(kHigh, 3) && !$past(rdSelN, 3)));
endmodule

// File: rtl/burst2_dp.sv
module burst2_dp
  import burst2_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [DATA_W/9-1:0]    byteSelN,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid
);
  localparam int LANE_W = 9;
  localparam int LANES  = DATA_W / LANE_W;

  logic [DATA_W-1:0] word0Reg;
  logic [LANES-1:0]  mask0Reg;
  logic [DATA_W-1:0] bankQ [2];
  logic [DATA_W-1:0] rdBuf [2];
  logic [DATA_W-1:0] hold1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word0Reg <= '0;
      mask0Reg <= '1;
    end else if (strb.capWord0) begin
      word0Reg <= wrData;
      mask0Reg <= byteSelN;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] bankWData;
    logic [LANES-1:0]  bankMaskN;
    if (b == 0) begin : g_first
      assign bankWData = word0Reg;
      assign bankMaskN = mask0Reg;
    end else begin : g_second
      assign bankWData = wrData;
      assign bankMaskN = byteSelN;
    end

    burst2_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk    (clk),
      .we     (strb.commitWrite),
      .wAddr  (addr),
      .wData  (bankWData),
      .wMaskN (bankMaskN),
      .rAddr  (addr),
      .rData  (bankQ[b])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             rdBuf[b] <= '0;
      else if (strb.capRead) rdBuf[b] <= bankQ[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      hold1   <= '0;
    end else if (strb.drvFirst) begin
      rdData  <= rdBuf[0];
      hold1   <= rdBuf[1];
      rdValid <= 1'b1;
    end else if (strb.drvSecond) begin
      rdData  <= hold1;
    end else if (strb.drvIdle) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end
  end

  // A burst always lasts at least two phases (R7)
  assert_pair_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |=> rdValid);

  // Output is zero while not valid (R8)
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  // Valid changes only at positive-phase edges (R8)
  assert_valid_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid != $past(rdValid)) |-> $past(strb.capWord0));
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
  import burst2_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   kHigh,
  input  logic                   rdSelN,
  input  logic                   wrSelN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [DATA_W/9-1:0]    byteSelN,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid
);
  strobe_t strb;

  burst2_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .kHigh  (kHigh),
    .rdSelN (rdSelN),
    .wrSelN (wrSelN),
    .strb   (strb)
  );

  burst2_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .wrData   (wrData),
    .byteSelN (byteSelN),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  // Reset state (R1)
  always_comb begin
    if (!rstN) assert_reset_idle_R1: assert (!rdValid && rdData == '0);
  end
endmodule

// File: tb/sim_burst2_sram.sv
module sim_burst2_sram;
  localparam int DATA_W = 36;
  localparam int ADDR_W = 4;
  localparam int LANES  = DATA_W / 9;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 0;
  logic rstN = 0;
  logic kHigh = 0;
  logic rdSelN = 1, wrSelN = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [LANES-1:0]  byteSelN = '1;
  logic [DATA_W-1:0] rdData;
  logic rdValid;

  always #5 clk = ~clk;

  burst2_sram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .kHigh(kHigh), .rdSelN(rdSelN), .wrSelN(wrSelN),
    .addr(addr), .wrData(wrData), .byteSelN(byteSelN), .rdData(rdData), .rdValid(rdValid)
  );

  typedef struct {
    logic [DATA_W-1:0] data;
    int                due;
    string             tag;
  } item_t;

  item_t expQ[$];
  logic [DATA_W-1:0] ref0 [DEPTH];
  logic [DATA_W-1:0] ref1 [DEPTH];
  int edgeCnt = 0;
  int checks = 0;
  int fails = 0;
  bit monOn = 0;
  bit done = 0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  function automatic logic [DATA_W-1:0] mk(int s);
    return DATA_W'({32'(s * 32'h9E3779B1), 32'(s * 32'h85EBCA6B)});
  endfunction

  function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old, logic [DATA_W-1:0] d,
                                              logic [LANES-1:0] m);
    logic [DATA_W-1:0] r = old;
    for (int l = 0; l < LANES; l++) if (!m[l]) r[l*9 +: 9] = d[l*9 +: 9];
    return r;
  endfunction

  // Driver: one input cycle = positive phase then negative phase
  task automatic burst(input bit doRd, input logic [ADDR_W-1:0] ra,
                       input bit doWr, input logic [ADDR_W-1:0] wa,
                       input logic [DATA_W-1:0] d0, input logic [LANES-1:0] m0,
                       input logic [DATA_W-1:0] d1, input logic [LANES-1:0] m1,
                       input string tag);
    item_t it;
    @(negedge clk);
    kHigh = 1; rdSelN = !doRd; wrSelN = !doWr; addr = ra; wrData = d0; byteSelN = m0;
    if (doRd) begin
      it.data = ref0[ra]; it.due = edgeCnt + 3; it.tag = tag; expQ.push_back(it);
      it.data = ref1[ra]; it.due = edgeCnt + 4; it.tag = tag; expQ.push_back(it);
    end
    @(negedge clk);
    kHigh = 0; rdSelN = 1; wrSelN = 1; addr = wa; wrData = d1; byteSelN = m1;
    if (doWr) begin
      ref0[wa] = merge(ref0[wa], d0, m0);
      ref1[wa] = merge(ref1[wa], d1, m1);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) burst(0, '0, 0, '0, mk(900 + i), '0, mk(950 + i), '0, "R3");
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    burst(1, a, 0, '0, '0, '1, '0, '1, tag);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d0,
                    input logic [LANES-1:0] m0, input logic [DATA_W-1:0] d1,
                    input logic [LANES-1:0] m1);
    burst(0, '0, 1, a, d0, m0, d1, m1, "R2");
  endtask

  // Monitor: compares due items, otherwise expects an idle output
  always @(negedge clk) begin
    if (monOn && !done) begin
      checks++;
      if (expQ.size() > 0 && expQ[0].due == edgeCnt) begin
        if (!rdValid || rdData !== expQ[0].data) begin
          fails++;
          $display("FAIL %s R6 R7: valid=%0b data=%h expected valid=1 data=%h",
                   expQ[0].tag, rdValid, rdData, expQ[0].data);
        end
        void'(expQ.pop_front());
      end else if (rdValid || rdData !== '0) begin
        fails++;
        $display("FAIL R7 R8 idle: valid=%0b data=%h expected valid=0 data=0", rdValid, rdData);
      end
    end
  end

  initial begin
    fork
      begin
        #2_000_000;
        if (!done) begin
          done = 1;
          checks++; fails++;
          $display("FAIL watchdog: run incomplete, expected finish");
          $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
          $finish;
        end
      end
    join_none
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 2; i++) begin
      checks++;
      if (rdValid !== 1'b0 || rdData !== '0) begin
        fails++;
        $display("FAIL R1: valid=%0b data=%h expected 0/0", rdValid, rdData);
      end
      @(negedge clk);
    end
    rstN = 1; kHigh = 0; monOn = 1;

    // R2 preload every pair with full writes
    for (int a = 0; a < DEPTH; a++) wr(ADDR_W'(a), mk(a), '0, mk(100 + a), '0);
    idle(1);
    // R6 single reads, R8 idle gaps after each
    for (int a = 0; a < DEPTH; a++) begin
      rd(ADDR_W'(a), "R6");
      idle(2);
    end
    // R7 back-to-back reads
    rd(4'd3, "R7"); rd(4'd9, "R7"); rd(4'd0, "R7"); rd(4'd15, "R7");
    idle(3);
    // R4 lane masks
    wr(4'd2, mk(200), LANES'(4'b1010), mk(201), LANES'(4'b1010));
    wr(4'd7, mk(202), LANES'(4'b1110), mk(203), LANES'(4'b0111));
    rd(4'd2, "R4"); rd(4'd7, "R4");
    idle(2);
    // R5 differing masks per word
    wr(4'd11, mk(300), LANES'(4'b0000), mk(301), LANES'(4'b1111));
    wr(4'd12, mk(302), LANES'(4'b1111), mk(303), LANES'(4'b0101));
    rd(4'd11, "R5"); rd(4'd12, "R5");
    idle(2);
    // R3 deselected write carrying data, mask and address
    burst(0, 4'd1, 0, 4'd5, mk(400), '0, mk(401), '0, "R3");
    burst(0, 4'd1, 0, 4'd6, mk(402), '0, mk(403), '0, "R3");
    rd(4'd5, "R3"); rd(4'd6, "R3");
    idle(2);
    // R9 same pair read and write in one cycle, then a read of the new data
    burst(1, 4'd8, 1, 4'd8, mk(500), '0, mk(501), LANES'(4'b0011), "R9");
    rd(4'd8, "R9");
    // R9 and R6: read and write to different pairs in one cycle
    burst(1, 4'd10, 1, 4'd13, mk(502), '0, mk(503), '0, "R9");
    rd(4'd13, "R9");
    idle(4);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R6: %0d words not returned, expected 0", expQ.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule